// File: doc/BRIEF.md
# ATA PIO Strobe Timing Generator

This block produces the read and write strobes for one parallel ATA channel during PIO and multiword DMA transfers. It holds a packed 32-bit timing word. From fields of that word it takes separate setup, active and recovery counts for data-port accesses and for task-file register accesses. For each accepted request the block runs a setup phase, drives the selected strobe low for the active phase, and holds the strobe high for the recovery phase. It raises `done` in the last recovery cycle.

The timing word is written through a masked-update port. The caller names a mode class (PIO, multiword DMA or Ultra DMA). Only the bits that belong to that class are replaced, and every other bit keeps its value. The values in effect for a transfer are latched when the request is accepted, so a write during a transfer changes nothing until the next request.

Requests that chain back to back skip the setup phase. A request chains when it is presented in the `done` cycle and has the same access type and direction as the transfer that is finishing. The block also drives the data bus output enable for write transfers. Ultra DMA bursts, IORDY wait states and the DMA engine are not part of this block.

Top module: `pata_strobe_gen`

## Requirements
- R1: After reset both strobes are high, `busy`, `done` and `bus_drive` are low, and `cfg_rdata` reads 0.
- R2: A write with `cfg_class`=0 (PIO) replaces exactly the bits set in mask 0xCFC3FFFF with `cfg_wdata`. All other bits keep their old value.
- R3: `cfg_class`=1 (multiword DMA) uses mask 0x31C001FF and `cfg_class`=2 (Ultra DMA) uses mask 0x303C0000. `cfg_class`=3 changes no bit.
- R4: A data access (`req_regacc`=0) takes its setup from bits 24:22, its active time from bits 8:4 and its recovery time from bits 3:0. Each phase lasts the field value plus one clock.
- R5: A task-file access (`req_regacc`=1) takes its setup from bits 27:25, its active time from bits 17:13 and its recovery time from bits 12:9. Each phase uses the same value-plus-one rule.
- R6: A transfer with `req_write`=1 pulses only `wr_strobe_n`, and one with `req_write`=0 pulses only `rd_strobe_n`. The two strobes are never low together.
- R7: `done` is a single-cycle pulse in the last recovery cycle. `req_ready` is high in that cycle and whenever the block is idle.
- R8: A request accepted in the `done` cycle with the same access type and direction goes straight to the active phase, with no setup.
- R9: A request accepted in the `done` cycle with a different access type or direction gets the full setup phase.
- R10: A timing-word write during a transfer does not change that transfer's phases. The next accepted request uses the new word.
- R11: `bus_drive` is high in every cycle of a write transfer (setup through recovery) and low during read transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Masked write strobe for the timing word |
| cfg_class | input | 2 | Mode class selecting the write mask (0 PIO, 1 MWDMA, 2 UDMA, 3 none) |
| cfg_wdata | input | 32 | Write data for the timing word |
| cfg_rdata | output | 32 | Current timing word |
| req_valid | input | 1 | Transfer request |
| req_regacc | input | 1 | 1 = task-file register access, 0 = data access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ready | output | 1 | Request is taken on this edge when `req_valid` is high |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | Last recovery cycle of a transfer |
| rd_strobe_n | output | 1 | Active-low read strobe |
| wr_strobe_n | output | 1 | Active-low write strobe |
| bus_drive | output | 1 | Data bus output enable for writes |

## Verification
The bench builds the block with the default counter width of five bits, which is exactly wide enough for the largest active field. This lets it reach the all-ones timing word: eight setup, thirty-two active and sixteen recovery clocks. It also runs the all-zero word, where every phase lasts a single clock. Chained runs of data reads exercise setup skipping. Chains that switch direction or access type check that the setup phase returns. A timing write issued while a long transfer is in flight checks that the update is deferred to the next request.

// File: rtl/pstb_pkg.sv
package pstb_pkg;

  // Word width of the packed timing register.
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    CLS_PIO   = 2'd0,
    CLS_MWDMA = 2'd1,
    CLS_UDMA  = 2'd2,
    CLS_NONE  = 2'd3
  } mode_class_e;

  // Phase counts for one kind of access, each stored as (clocks - 1).
  typedef struct packed {
    logic [2:0] setup;
    logic [4:0] active;
    logic [3:0] recov;
  } phase_t;

  // Bits that a masked update of the given class may replace.
  function automatic logic [WORD_W-1:0] class_mask(input logic [1:0] cls);
    case (cls)
      CLS_PIO:   return 32'hCFC3_FFFF;
      CLS_MWDMA: return 32'h31C0_01FF;
      CLS_UDMA:  return 32'h303C_0000;
      default:   return 32'h0000_0000;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] merge_word(input logic [WORD_W-1:0] old_w,
                                                  input logic [WORD_W-1:0] new_w,
                                                  input logic [WORD_W-1:0] msk);
    return (old_w & ~msk) | (new_w & msk);
  endfunction

  // Pick the field set for a data access or a task-file register access.
  function automatic phase_t pick_phase(input logic [WORD_W-1:0] w, input logic regacc);
    phase_t p;
    if (regacc) begin
      p.setup  = w[27:25];
      p.active = w[17:13];
      p.recov  = w[12:9];
    end else begin
      p.setup  = w[24:22];
      p.active = w[8:4];
      p.recov  = w[3:0];
    end
    return p;
  endfunction

endpackage

// File: rtl/pstb_timing_reg.sv
module pstb_timing_reg
  import pstb_pkg::*;
#(
  parameter logic [WORD_W-1:0] RESET_WORD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_class,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] word_o
);

  logic [WORD_W-1:0] upd_mask;
  assign upd_mask = class_mask(cfg_class);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word_o <= RESET_WORD;
    else if (cfg_wr) word_o <= merge_word(word_o, cfg_wdata, upd_mask);
  end

  // R2: bits outside the mask of the last write did not move
  p_mask_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (((word_o ^ $past(word_o)) & ~$past(upd_mask)) == '0));

  // R3: the empty class leaves the word alone
  p_none_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_class == 2'd3) |=> $stable(word_o));

endmodule

// File: rtl/pstb_sequencer.sv
module pstb_sequencer
  import pstb_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int RUN_W = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] tword,
  input  logic              req_valid,
  input  logic              req_regacc,
  input  logic              req_write,
  output logic              req_ready,
  output logic              busy,
  output logic              done,
  output logic              rd_n,
  output logic              wr_n,
  output logic              bus_oe
);

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_ACT, ST_REC} seq_st_e;

  seq_st_e          state;
  logic [CNT_W-1:0] cnt;
  logic             lat_regacc, lat_wr;
  logic [4:0]       lat_act;
  logic [3:0]       lat_rec;
  phase_t           nxt_ph;

  // Named events for the assertions
  logic accept, chain, strobe_low, cnt_zero;

  assign nxt_ph     = pick_phase(tword, req_regacc);
  assign cnt_zero   = (cnt == '0);
  assign done       = (state == ST_REC) && cnt_zero;
  assign busy       = (state != ST_IDLE);
  assign req_ready  = !busy || done;
  assign accept     = req_valid && req_ready;
  assign chain      = accept && done && (req_regacc == lat_regacc) && (req_write == lat_wr);
  assign strobe_low = (state == ST_ACT);
  assign rd_n       = !(strobe_low && !lat_wr);
  assign wr_n       = !(strobe_low && lat_wr);
  assign bus_oe     = busy && lat_wr;

  function automatic logic [CNT_W-1:0] ext(input logic [4:0] v);
    return CNT_W'(v);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      lat_regacc <= 1'b0;
      lat_wr     <= 1'b0;
      lat_act    <= '0;
      lat_rec    <= '0;
    end else if (accept) begin
      lat_regacc <= req_regacc;
      lat_wr     <= req_write;
      lat_act    <= nxt_ph.active;
      lat_rec    <= nxt_ph.recov;
      if (chain) begin
        state <= ST_ACT;
        cnt   <= ext(nxt_ph.active);
      end else begin
        state <= ST_SETUP;
        cnt   <= ext({2'b00, nxt_ph.setup});
      end
    end else begin
      case (state)
        ST_SETUP: if (cnt_zero) begin state <= ST_ACT; cnt <= ext(lat_act); end
                  else cnt <= cnt - CNT_W'(1);
        ST_ACT:   if (cnt_zero) begin state <= ST_REC; cnt <= ext({1'b0, lat_rec}); end
                  else cnt <= cnt - CNT_W'(1);
        ST_REC:   if (cnt_zero) state <= ST_IDLE;
                  else cnt <= cnt - CNT_W'(1);
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // Run-length of the low strobe, kept for the active-length check
  logic [RUN_W-1:0] low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_run <= '0;
    else if (strobe_low) low_run <= low_run + RUN_W'(1);
    else                 low_run <= '0;
  end

  // R6: never both strobes low
  p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R4/R5: a finished low phase lasted the latched field plus one
  p_active_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(strobe_low) && !strobe_low) |-> (low_run == RUN_W'(lat_act) + RUN_W'(1)));

  // R7: done lasts one cycle only
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: a chained request goes low on the next cycle
  p_chain_skip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    chain |=> strobe_low);

  // R11: a low write strobe always has the bus driven
  p_drive_on_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> bus_oe);

endmodule

// File: rtl/pata_strobe_gen.sv
module pata_strobe_gen
  import pstb_pkg::*;
#(
  parameter int                CNT_W      = 5,
  parameter logic [WORD_W-1:0] RESET_WORD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_class,
  input  logic [WORD_W-1:0] cfg_wdata,
  output logic [WORD_W-1:0] cfg_rdata,
  input  logic              req_valid,
  input  logic              req_regacc,
  input  logic              req_write,
  output logic              req_ready,
  output logic              busy,
  output logic              done,
  output logic              rd_strobe_n,
  output logic              wr_strobe_n,
  output logic              bus_drive
);

  localparam int RUN_W = CNT_W + 1;

  logic [WORD_W-1:0] tword;

  pstb_timing_reg #(.RESET_WORD(RESET_WORD)) u_treg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_class (cfg_class),
    .cfg_wdata (cfg_wdata),
    .word_o    (tword)
  );

  pstb_sequencer #(.CNT_W(CNT_W), .RUN_W(RUN_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .tword      (tword),
    .req_valid  (req_valid),
    .req_regacc (req_regacc),
    .req_write  (req_write),
    .req_ready  (req_ready),
    .busy       (busy),
    .done       (done),
    .rd_n       (rd_strobe_n),
    .wr_n       (wr_strobe_n),
    .bus_oe     (bus_drive)
  );

  assign cfg_rdata = tword;

  // R1: strobes idle high whenever nothing is in flight
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rd_strobe_n && wr_strobe_n && !bus_drive));

endmodule

// File: tb/test_pata_strobe_gen.sv
`timescale 1ns/1ps
module test_pata_strobe_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_class = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_regacc = 1'b0;
  logic        req_write = 1'b0;
  logic        req_ready, busy, done, rd_strobe_n, wr_strobe_n, bus_drive;

  always #2.5 clk = ~clk;

  pata_strobe_gen i_pata_strobe_gen (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_class(cfg_class),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_regacc(req_regacc), .req_write(req_write), .req_ready(req_ready),
    .busy(busy), .done(done), .rd_strobe_n(rd_strobe_n),
    .wr_strobe_n(wr_strobe_n), .bus_drive(bus_drive)
  );

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  typedef struct packed {
    logic [7:0] setup;
    logic [7:0] act;
    logic [7:0] rec;
    logic       wr;
    logic [7:0] stag;
    logic [7:0] ftag;
  } exp_t;

  exp_t        q[$];
  logic [31:0] mirror = '0;
  logic        last_regacc = 1'b0;
  logic        last_wr = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bench view of the update rule and field layout
  function automatic logic [31:0] mask_of(input logic [1:0] c);
    logic [31:0] m;
    m = '0;
    if (c == 2'd0) m = ~(32'h3 << 28) & ~(32'hF << 18);
    if (c == 2'd1) m = (32'h3 << 28) | (32'h7 << 22) | 32'h1FF;
    if (c == 2'd2) m = (32'h3 << 28) | (32'hF << 18);
    return m;
  endfunction

  function automatic logic [31:0] mk(input int ds, input int da, input int dr,
                                     input int ts, input int ta, input int tr);
    return (32'(ds) << 22) | (32'(da) << 4) | 32'(dr) |
           (32'(ts) << 25) | (32'(ta) << 13) | (32'(tr) << 9);
  endfunction

  task automatic cfg_write(input logic [1:0] c, input logic [31:0] d, input string req);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_class = c; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    mirror = (mirror & ~mask_of(c)) | (d & mask_of(c));
    chk(cfg_rdata == mirror, req, cfg_rdata, mirror);
  endtask

  // Driver: present a request, wait for acceptance, push the expectation
  task automatic issue(input logic ra, input logic wr, input logic [7:0] ftag_in);
    exp_t e;
    bit   chained;
    int   ds, da, dr;
    @(negedge clk);
    req_valid = 1'b1; req_regacc = ra; req_write = wr;
    while (!req_ready) @(negedge clk);
    chained = busy && (ra == last_regacc) && (wr == last_wr);
    if (ra) begin
      ds = int'((mirror >> 25) & 7); da = int'((mirror >> 13) & 31); dr = int'((mirror >> 9) & 15);
    end else begin
      ds = int'((mirror >> 22) & 7); da = int'((mirror >> 4) & 31); dr = int'(mirror & 15);
    end
    e.setup = chained ? 8'd0 : 8'(ds + 1);
    e.act   = 8'(da + 1);
    e.rec   = 8'(dr + 1);
    e.wr    = wr;
    e.stag  = chained ? 8'd8 : (busy ? 8'd9 : (ra ? 8'd5 : 8'd4));
    e.ftag  = ftag_in;
    q.push_back(e);
    last_regacc = ra; last_wr = wr;
  endtask

  task automatic release_req();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    chk(q.size() == 0, "R7 all transfers completed", q.size(), 0);
  endtask

  // Monitor: measure phases at the negedge and compare with the queue head
  int pre_c = 0, low_c = 0, post_c = 0;
  bit seen_low = 0, sel_bad = 0, oe_bad = 0;
  always @(negedge clk) begin
    if (rst_n && !finished && busy) begin
      if (q.size() > 0) begin
        if (bus_drive != q[0].wr) oe_bad = 1;
        if (!rd_strobe_n || !wr_strobe_n) begin
          seen_low = 1; low_c++;
          if (q[0].wr ? (!rd_strobe_n || wr_strobe_n) : (!wr_strobe_n || rd_strobe_n)) sel_bad = 1;
        end else if (!seen_low) pre_c++;
        else post_c++;
        if (done) begin
          exp_t e;
          e = q.pop_front();
          chk(pre_c == int'(e.setup), $sformatf("R%0d setup clocks", e.stag), pre_c, e.setup);
          chk(low_c == int'(e.act), $sformatf("R%0d active clocks", e.ftag), low_c, e.act);
          chk(post_c == int'(e.rec), $sformatf("R%0d recovery clocks", e.ftag), post_c, e.rec);
          chk(!sel_bad, "R6 strobe selection", sel_bad, 0);
          chk(!oe_bad, "R11 bus drive", oe_bad, 0);
          chk(req_ready, "R7 ready in done cycle", req_ready, 1);
          pre_c = 0; low_c = 0; post_c = 0; seen_low = 0; sel_bad = 0; oe_bad = 0;
        end
      end else begin
        chk(0, "R7 busy without a pending request", busy, 0);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++; n_fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(rd_strobe_n && wr_strobe_n, "R1 strobes high", {rd_strobe_n, wr_strobe_n}, 2'b11);
    chk(!busy && !done && !bus_drive, "R1 idle flags", {busy, done, bus_drive}, 0);
    chk(cfg_rdata == 32'h0, "R1 word cleared", cfg_rdata, 0);

    // R2 PIO update with distinct data and task-file fields, top bits set too
    cfg_write(2'd0, mk(2, 3, 1, 1, 6, 2) | 32'hF03C_0000, "R2 PIO masked update");

    // R4 / R5 / R6 / R11 single transfers of each kind
    issue(1'b0, 1'b0, 8'd4); release_req(); wait_idle();
    issue(1'b0, 1'b1, 8'd4); release_req(); wait_idle();
    issue(1'b1, 1'b0, 8'd5); release_req(); wait_idle();
    issue(1'b1, 1'b1, 8'd5); release_req(); wait_idle();

    // R8 chained data reads, then R9 direction and access-type changes
    issue(1'b0, 1'b0, 8'd4);
    issue(1'b0, 1'b0, 8'd4);
    issue(1'b0, 1'b0, 8'd4);
    issue(1'b0, 1'b1, 8'd4);
    issue(1'b1, 1'b1, 8'd5);
    issue(1'b1, 1'b1, 8'd5);
    release_req(); wait_idle();

    // R3 other classes, including the empty one
    cfg_write(2'd1, 32'hFFFF_FFFF, "R3 MWDMA masked update");
    cfg_write(2'd2, 32'h0000_0000, "R3 UDMA masked update");
    cfg_write(2'd3, 32'h0000_0000, "R3 empty class ignored");

    // R4 boundary: all-ones data fields
    issue(1'b0, 1'b1, 8'd4); release_req(); wait_idle();

    // R10 write during a long transfer does not touch it
    issue(1'b0, 1'b0, 8'd10); release_req();
    repeat (3) @(negedge clk);
    cfg_wr = 1'b1; cfg_class = 2'd0; cfg_wdata = mk(0, 0, 0, 7, 31, 15);
    @(negedge clk);
    cfg_wr = 1'b0;
    mirror = (mirror & ~mask_of(2'd0)) | (mk(0, 0, 0, 7, 31, 15) & mask_of(2'd0));
    chk(busy, "R10 write landed mid-transfer", busy, 1);
    wait_idle();

    // R10 the next request uses the new word: minimum data phases
    issue(1'b0, 1'b0, 8'd10); release_req(); wait_idle();
    // R5 boundary: maximum task-file phases
    issue(1'b1, 1'b0, 8'd5); release_req(); wait_idle();

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule